// File: doc/BRIEF.md
# Region-Partitioned Data Address Translator

This block turns data virtual addresses into physical page numbers. Three small fully associative translation buffers sit behind it, one each for stack, static global data and heap. For every request, a router compares the virtual address against three boundary registers that software loads. It then sends the lookup to the buffer for that region only. The stack buffer has two lookup ports. The global and heap buffers have one port each.

Up to two requests arrive per cycle. When both need the same single-ported buffer in the same cycle, one of them is stalled and must be presented again. The block reports the translation of each serviced request one cycle later. A miss is reported with its region and page number, and the requester then supplies the missing entry through a refill port. A flush input invalidates every entry at once. Loading new boundaries does the same.

Addresses are 32 bits wide with 4 KB pages, so the virtual and physical page numbers are 20 bits each. Region codes are 0 for stack, 1 for global and 2 for heap.

Top module: `sem_dtlb`

## Requirements
- R1: An address at or above (stack base minus STACK_SPAN) is classified stack (code 0). Otherwise, an address at or above the data base and below the data bound is global (code 1). Any other address is heap (code 2). The classification uses the boundary values held before the request's clock edge.
- R2: A request is looked up only in the buffer of its own region. An entry refilled into another region never produces a hit for it.
- R3: One cycle after a serviced request, resp_valid is high for that port. On a hit, resp_hit is high and resp_ppn and resp_ro carry the stored entry. resp_region and resp_vpn (address bits 31:12) always describe the request.
- R4: A serviced request that matches no valid entry gives resp_miss high, resp_hit low, and the request's region and VPN, one cycle after the request.
- R5: A refill (refill_valid with region code, VPN, PPN and read-only flag) writes one entry into that region's buffer. Lookups from the next cycle on see the entry. A lookup in the same cycle sees the old contents.
- R6: A refill goes to the lowest-numbered invalid entry. When all entries are valid, it replaces the entry under a round-robin pointer, which then advances and wraps. Sizes are 4 (stack), 8 (global) and 32 (heap) entries. The pointer restarts at entry 0 after reset or a flush.
- R7: Two requests to the stack region in one cycle are both serviced, with no stall.
- R8: When both ports request the same single-ported region (global or heap), port 0 is serviced and stall[1] is raised in the same cycle. A stalled request is not serviced and produces no response.
- R9: In the cycle after a port 1 stall, port 1 has priority. If port 0 then conflicts, stall[0] is raised instead. Port 1 is never stalled in two consecutive cycles.
- R10: flush invalidates every entry of all three buffers from the next cycle on. If flush and refill fall in the same cycle, the flush wins.
- R11: cfg_load loads the three boundary registers and flushes all buffers in the same cycle.
- R12: After reset, there are no responses and no stalls, all buffers are empty and the boundaries are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 2 | Request valid per port |
| req_va0 | input | 32 | Port 0 virtual address |
| req_va1 | input | 32 | Port 1 virtual address |
| stall | output | 2 | Request not accepted this cycle, per port |
| resp_valid | output | 2 | Response present, per port |
| resp_hit | output | 2 | Translation found |
| resp_miss | output | 2 | Translation missing |
| resp_ro | output | 2 | Read-only flag of the hit entry |
| resp_ppn0 | output | 20 | Port 0 physical page number |
| resp_ppn1 | output | 20 | Port 1 physical page number |
| resp_region0 | output | 2 | Port 0 region code |
| resp_region1 | output | 2 | Port 1 region code |
| resp_vpn0 | output | 20 | Port 0 virtual page number |
| resp_vpn1 | output | 20 | Port 1 virtual page number |
| refill_valid | input | 1 | Write one entry |
| refill_region | input | 2 | Region code of the entry |
| refill_vpn | input | 20 | Entry virtual page number |
| refill_ppn | input | 20 | Entry physical page number |
| refill_ro | input | 1 | Entry read-only flag |
| flush | input | 1 | Invalidate all entries |
| cfg_load | input | 1 | Load boundaries and flush |
| cfg_data_base | input | 32 | Lowest global address |
| cfg_data_bound | input | 32 | First address above global data |
| cfg_stack_base | input | 32 | Top of the stack region |

## Verification
The stall flags are combinational, so they are due in the same cycle as the request. The bench samples them one time unit after it drives the inputs, before the clock edge. Each response is registered once and appears just after the edge that captures its request. The bench compares every response output one time unit after that edge, against a model that computed the expected value from state held before the edge. Refills, flushes and boundary loads change the model only after that computation, so same-cycle lookups are expected to see the old contents and old bounds.

// File: rtl/sem_dtlb_pkg.sv
package sem_dtlb_pkg;
  localparam int VA_W   = 32;
  localparam int PG_OFF = 12;
  localparam int VPN_W  = VA_W - PG_OFF;
  localparam int PPN_W  = 20;

  typedef enum logic [1:0] {
    RGN_STACK  = 2'd0,
    RGN_GLOBAL = 2'd1,
    RGN_HEAP   = 2'd2
  } rgn_e;

  // Priority classification: stack window first, then static data window.
  function automatic rgn_e classify_va(input logic [VA_W-1:0] va,
                                       input logic [VA_W-1:0] data_base,
                                       input logic [VA_W-1:0] data_bound,
                                       input logic [VA_W-1:0] stack_floor);
    if (va >= stack_floor)
      return RGN_STACK;
    else if (va >= data_base && va < data_bound)
      return RGN_GLOBAL;
    else
      return RGN_HEAP;
  endfunction
endpackage

// File: rtl/sem_region_router.sv
module sem_region_router
  import sem_dtlb_pkg::*;
#(
  parameter logic [VA_W-1:0] STACK_SPAN = 32'h0010_0000
) (
  input  logic [VA_W-1:0] va,
  input  logic [VA_W-1:0] data_base,
  input  logic [VA_W-1:0] data_bound,
  input  logic [VA_W-1:0] stack_base,
  output rgn_e            rgn
);
  logic [VA_W-1:0] stack_floor;
  assign stack_floor = stack_base - STACK_SPAN;
  assign rgn = classify_va(va, data_base, data_bound, stack_floor);
endmodule

// File: rtl/sem_port_arbiter.sv
module sem_port_arbiter
  import sem_dtlb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] req_valid,
  input  rgn_e       rgn0,
  input  rgn_e       rgn1,
  output logic [1:0] stall,
  output logic [1:0] served
);
  logic p1_prio_q;
  logic same_single;
  logic clash;

  assign same_single = (rgn0 == rgn1) && (rgn0 != RGN_STACK);
  assign clash       = req_valid[0] && req_valid[1] && same_single;
  assign stall[0]    = clash && p1_prio_q;
  assign stall[1]    = clash && !p1_prio_q;
  assign served      = req_valid & ~stall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) p1_prio_q <= 1'b0;
    else        p1_prio_q <= stall[1];
  end

  // R7
  stack_dual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid == 2'b11 && rgn0 == RGN_STACK && rgn1 == RGN_STACK) |-> (served == 2'b11));

  // R9
  p1_no_double_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall[1] |=> !stall[1]);
endmodule

// File: rtl/sem_tlb_bank.sv
module sem_tlb_bank
  import sem_dtlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int NPORTS  = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             wr_en,
  input  logic [VPN_W-1:0] wr_vpn,
  input  logic [PPN_W-1:0] wr_ppn,
  input  logic             wr_ro,
  input  logic [VPN_W-1:0] lk_vpn [NPORTS],
  output logic             lk_hit [NPORTS],
  output logic [PPN_W-1:0] lk_ppn [NPORTS],
  output logic             lk_ro  [NPORTS]
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

  logic [ENTRIES-1:0] valid_q;
  logic [VPN_W-1:0]   vpn_q [ENTRIES];
  logic [PPN_W-1:0]   ppn_q [ENTRIES];
  logic               ro_q  [ENTRIES];
  logic [IDX_W-1:0]   rr_ptr_q;

  // Returns {found, index} of the lowest invalid entry.
  function automatic logic [IDX_W:0] pick_free(input logic [ENTRIES-1:0] v);
    logic [IDX_W:0] r;
    r = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (!v[i]) r = {1'b1, IDX_W'(i)};
    return r;
  endfunction

  logic [IDX_W:0]   free_pick;
  logic             free_found;
  logic [IDX_W-1:0] victim_idx;

  assign free_pick  = pick_free(valid_q);
  assign free_found = free_pick[IDX_W];
  assign victim_idx = free_found ? free_pick[IDX_W-1:0] : rr_ptr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q  <= '0;
      rr_ptr_q <= '0;
    end else if (flush) begin
      valid_q  <= '0;
      rr_ptr_q <= '0;
    end else if (wr_en) begin
      valid_q[victim_idx] <= 1'b1;
      if (!free_found)
        rr_ptr_q <= (rr_ptr_q == LAST_IDX) ? '0 : rr_ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && !flush) begin
      vpn_q[victim_idx] <= wr_vpn;
      ppn_q[victim_idx] <= wr_ppn;
      ro_q[victim_idx]  <= wr_ro;
    end
  end

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    always_comb begin
      lk_hit[p] = 1'b0;
      lk_ppn[p] = '0;
      lk_ro[p]  = 1'b0;
      for (int e = 0; e < ENTRIES; e++) begin
        if (valid_q[e] && vpn_q[e] == lk_vpn[p]) begin
          lk_hit[p] = 1'b1;
          lk_ppn[p] = ppn_q[e];
          lk_ro[p]  = ro_q[e];
        end
      end
    end
  end

  // R10
  flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (valid_q == '0));

  // R5
  refill_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !flush) |=> valid_q[$past(victim_idx)]);
endmodule

// File: rtl/sem_dtlb.sv
module sem_dtlb
  import sem_dtlb_pkg::*;
#(
  parameter int STACK_ENTRIES  = 4,
  parameter int GLOBAL_ENTRIES = 8,
  parameter int HEAP_ENTRIES   = 32,
  parameter logic [31:0] STACK_SPAN = 32'h0010_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  req_valid,
  input  logic [31:0] req_va0,
  input  logic [31:0] req_va1,
  output logic [1:0]  stall,
  output logic [1:0]  resp_valid,
  output logic [1:0]  resp_hit,
  output logic [1:0]  resp_miss,
  output logic [1:0]  resp_ro,
  output logic [19:0] resp_ppn0,
  output logic [19:0] resp_ppn1,
  output logic [1:0]  resp_region0,
  output logic [1:0]  resp_region1,
  output logic [19:0] resp_vpn0,
  output logic [19:0] resp_vpn1,
  input  logic        refill_valid,
  input  logic [1:0]  refill_region,
  input  logic [19:0] refill_vpn,
  input  logic [19:0] refill_ppn,
  input  logic        refill_ro,
  input  logic        flush,
  input  logic        cfg_load,
  input  logic [31:0] cfg_data_base,
  input  logic [31:0] cfg_data_bound,
  input  logic [31:0] cfg_stack_base
);
  localparam int NPORT = 2;

  logic [VA_W-1:0] data_base_q, data_bound_q, stack_base_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_base_q  <= '0;
      data_bound_q <= '0;
      stack_base_q <= '0;
    end else if (cfg_load) begin
      data_base_q  <= cfg_data_base;
      data_bound_q <= cfg_data_bound;
      stack_base_q <= cfg_stack_base;
    end
  end

  logic flush_all;
  assign flush_all = flush | cfg_load;

  logic [VA_W-1:0]  va  [NPORT];
  logic [VPN_W-1:0] vpn [NPORT];
  rgn_e             rgn [NPORT];
  assign va[0] = req_va0;
  assign va[1] = req_va1;

  for (genvar p = 0; p < NPORT; p++) begin : g_route
    assign vpn[p] = va[p][VA_W-1:PG_OFF];
    sem_region_router #(.STACK_SPAN(STACK_SPAN)) u_router (
      .va(va[p]), .data_base(data_base_q), .data_bound(data_bound_q),
      .stack_base(stack_base_q), .rgn(rgn[p]));
  end

  logic [1:0] served;
  sem_port_arbiter u_arb (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
    .rgn0(rgn[0]), .rgn1(rgn[1]), .stall(stall), .served(served));

  // Single-ported buffers take port 1 only when it is the one serviced.
  logic [VPN_W-1:0] glb_vpn [1];
  logic [VPN_W-1:0] hp_vpn  [1];
  assign glb_vpn[0] = (served[1] && rgn[1] == RGN_GLOBAL) ? vpn[1] : vpn[0];
  assign hp_vpn[0]  = (served[1] && rgn[1] == RGN_HEAP)   ? vpn[1] : vpn[0];

  logic             stk_hit [NPORT];
  logic [PPN_W-1:0] stk_ppn [NPORT];
  logic             stk_ro  [NPORT];
  logic             glb_hit [1];
  logic [PPN_W-1:0] glb_ppn [1];
  logic             glb_ro  [1];
  logic             hp_hit  [1];
  logic [PPN_W-1:0] hp_ppn  [1];
  logic             hp_ro   [1];

  sem_tlb_bank #(.ENTRIES(STACK_ENTRIES), .NPORTS(2)) u_stack (
    .clk(clk), .rst_n(rst_n), .flush(flush_all),
    .wr_en(refill_valid && refill_region == RGN_STACK),
    .wr_vpn(refill_vpn), .wr_ppn(refill_ppn), .wr_ro(refill_ro),
    .lk_vpn(vpn), .lk_hit(stk_hit), .lk_ppn(stk_ppn), .lk_ro(stk_ro));

  sem_tlb_bank #(.ENTRIES(GLOBAL_ENTRIES), .NPORTS(1)) u_global (
    .clk(clk), .rst_n(rst_n), .flush(flush_all),
    .wr_en(refill_valid && refill_region == RGN_GLOBAL),
    .wr_vpn(refill_vpn), .wr_ppn(refill_ppn), .wr_ro(refill_ro),
    .lk_vpn(glb_vpn), .lk_hit(glb_hit), .lk_ppn(glb_ppn), .lk_ro(glb_ro));

  sem_tlb_bank #(.ENTRIES(HEAP_ENTRIES), .NPORTS(1)) u_heap (
    .clk(clk), .rst_n(rst_n), .flush(flush_all),
    .wr_en(refill_valid && refill_region == RGN_HEAP),
    .wr_vpn(refill_vpn), .wr_ppn(refill_ppn), .wr_ro(refill_ro),
    .lk_vpn(hp_vpn), .lk_hit(hp_hit), .lk_ppn(hp_ppn), .lk_ro(hp_ro));

  logic             lk_hit [NPORT];
  logic [PPN_W-1:0] lk_ppn [NPORT];
  logic             lk_ro  [NPORT];
  always_comb begin
    for (int p = 0; p < NPORT; p++) begin
      case (rgn[p])
        RGN_STACK: begin
          lk_hit[p] = stk_hit[p]; lk_ppn[p] = stk_ppn[p]; lk_ro[p] = stk_ro[p];
        end
        RGN_GLOBAL: begin
          lk_hit[p] = glb_hit[0]; lk_ppn[p] = glb_ppn[0]; lk_ro[p] = glb_ro[0];
        end
        default: begin
          lk_hit[p] = hp_hit[0];  lk_ppn[p] = hp_ppn[0];  lk_ro[p] = hp_ro[0];
        end
      endcase
    end
  end

  logic [PPN_W-1:0] ppn_q [NPORT];
  logic [1:0]       rgn_q [NPORT];
  logic [VPN_W-1:0] vpn_q [NPORT];

  for (genvar p = 0; p < NPORT; p++) begin : g_resp
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        resp_valid[p] <= 1'b0;
        resp_hit[p]   <= 1'b0;
        resp_ro[p]    <= 1'b0;
        ppn_q[p]      <= '0;
        rgn_q[p]      <= '0;
        vpn_q[p]      <= '0;
      end else begin
        resp_valid[p] <= served[p];
        resp_hit[p]   <= served[p] && lk_hit[p];
        resp_ro[p]    <= served[p] && lk_hit[p] && lk_ro[p];
        ppn_q[p]      <= lk_ppn[p];
        rgn_q[p]      <= rgn[p];
        vpn_q[p]      <= vpn[p];
      end
    end
  end

  assign resp_miss    = resp_valid & ~resp_hit;
  assign resp_ppn0    = ppn_q[0];
  assign resp_ppn1    = ppn_q[1];
  assign resp_region0 = rgn_q[0];
  assign resp_region1 = rgn_q[1];
  assign resp_vpn0    = vpn_q[0];
  assign resp_vpn1    = vpn_q[1];

  // R3
  served_responds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    served[0] |=> resp_valid[0]);

  // R8
  stalled_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stall[1] && !served[1]) |=> !resp_valid[1]);
endmodule

// File: tb/test_sem_dtlb.sv
module test_sem_dtlb;
  localparam int CLK_P = 10;
  localparam logic [31:0] SPAN = 32'h0010_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic [1:0]  req_valid = '0;
  logic [31:0] req_va0 = '0, req_va1 = '0;
  logic [1:0]  stall, resp_valid, resp_hit, resp_miss, resp_ro;
  logic [19:0] resp_ppn0, resp_ppn1, resp_vpn0, resp_vpn1;
  logic [1:0]  resp_region0, resp_region1;
  logic        refill_valid = 1'b0;
  logic [1:0]  refill_region = '0;
  logic [19:0] refill_vpn = '0, refill_ppn = '0;
  logic        refill_ro = 1'b0, flush = 1'b0, cfg_load = 1'b0;
  logic [31:0] cfg_data_base = '0, cfg_data_bound = '0, cfg_stack_base = '0;

  sem_dtlb i_sem_dtlb (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va0(req_va0), .req_va1(req_va1),
    .stall(stall), .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_miss(resp_miss),
    .resp_ro(resp_ro), .resp_ppn0(resp_ppn0), .resp_ppn1(resp_ppn1),
    .resp_region0(resp_region0), .resp_region1(resp_region1),
    .resp_vpn0(resp_vpn0), .resp_vpn1(resp_vpn1),
    .refill_valid(refill_valid), .refill_region(refill_region), .refill_vpn(refill_vpn),
    .refill_ppn(refill_ppn), .refill_ro(refill_ro), .flush(flush), .cfg_load(cfg_load),
    .cfg_data_base(cfg_data_base), .cfg_data_bound(cfg_data_bound),
    .cfg_stack_base(cfg_stack_base));

  // Behavioural reference: per-region entry lists and pointers.
  int          m_size [3] = '{4, 8, 32};
  bit          m_v    [3][32];
  logic [19:0] m_vpn  [3][32];
  logic [19:0] m_ppn  [3][32];
  bit          m_ro   [3][32];
  int          m_ptr  [3];
  logic [31:0] m_base = '0, m_bound = '0, m_stack = '0;
  bit          m_prio = 1'b0;

  bit          e_valid [2];
  bit          e_hit   [2];
  logic [19:0] e_ppn   [2];
  bit          e_ro    [2];
  int          e_rgn   [2];
  logic [19:0] e_vpn   [2];

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int region_of(input logic [31:0] va);
    logic [31:0] floor_va;
    floor_va = m_stack - SPAN;
    if (va >= floor_va) return 0;
    if (va >= m_base && va < m_bound) return 1;
    return 2;
  endfunction

  task automatic model_clear();
    for (int r = 0; r < 3; r++) begin
      m_ptr[r] = 0;
      for (int e = 0; e < 32; e++) m_v[r][e] = 1'b0;
    end
  endtask

  // Inputs are driven after a falling edge; this evaluates one cycle.
  task automatic tick();
    int r [2];
    bit vreq [2];
    bit clash, es0, es1;
    logic [31:0] vas [2];
    #1;
    vas[0] = req_va0; vas[1] = req_va1;
    vreq[0] = req_valid[0]; vreq[1] = req_valid[1];
    r[0] = region_of(vas[0]); r[1] = region_of(vas[1]);
    clash = vreq[0] && vreq[1] && r[0] == r[1] && r[0] != 0;
    es0 = clash && m_prio;
    es1 = clash && !m_prio;
    chk("R8", "stall[1]", stall[1], es1);
    chk("R9", "stall[0]", stall[0], es0);
    for (int p = 0; p < 2; p++) begin
      e_valid[p] = vreq[p] && !(p == 0 ? es0 : es1);
      e_rgn[p] = r[p];
      e_vpn[p] = vas[p][31:12];
      e_hit[p] = 1'b0; e_ppn[p] = '0; e_ro[p] = 1'b0;
      for (int e = 0; e < m_size[r[p]]; e++)
        if (m_v[r[p]][e] && m_vpn[r[p]][e] == e_vpn[p]) begin
          e_hit[p] = 1'b1; e_ppn[p] = m_ppn[r[p]][e]; e_ro[p] = m_ro[r[p]][e];
        end
    end
    m_prio = es1;
    if (flush || cfg_load) begin
      model_clear();
      if (cfg_load) begin
        m_base = cfg_data_base; m_bound = cfg_data_bound; m_stack = cfg_stack_base;
      end
    end else if (refill_valid) begin
      int rr, slot;
      rr = int'(refill_region);
      slot = -1;
      for (int e = m_size[rr] - 1; e >= 0; e--) if (!m_v[rr][e]) slot = e;
      if (slot < 0) begin
        slot = m_ptr[rr];
        m_ptr[rr] = (m_ptr[rr] + 1) % m_size[rr];
      end
      m_v[rr][slot] = 1'b1; m_vpn[rr][slot] = refill_vpn;
      m_ppn[rr][slot] = refill_ppn; m_ro[rr][slot] = refill_ro;
    end
    @(posedge clk); #1;
    for (int p = 0; p < 2; p++) begin
      chk("R3", "resp_valid", resp_valid[p], e_valid[p]);
      if (e_valid[p]) begin
        chk("R1", "resp_region", p == 0 ? resp_region0 : resp_region1, e_rgn[p]);
        chk("R3", "resp_vpn", p == 0 ? resp_vpn0 : resp_vpn1, e_vpn[p]);
        chk("R2", "resp_hit", resp_hit[p], e_hit[p]);
        chk("R4", "resp_miss", resp_miss[p], !e_hit[p]);
        if (e_hit[p]) begin
          chk("R3", "resp_ppn", p == 0 ? resp_ppn0 : resp_ppn1, e_ppn[p]);
          chk("R3", "resp_ro", resp_ro[p], e_ro[p]);
        end
      end
    end
    @(negedge clk);
    req_valid = '0; refill_valid = 1'b0; flush = 1'b0; cfg_load = 1'b0;
  endtask

  task automatic acc(input bit v0, input logic [31:0] a0, input bit v1, input logic [31:0] a1);
    req_valid = {v1, v0}; req_va0 = a0; req_va1 = a1;
    tick();
  endtask

  task automatic fill(input logic [1:0] rg, input logic [19:0] vpn, input logic [19:0] ppn, input bit ro);
    refill_valid = 1'b1; refill_region = rg; refill_vpn = vpn; refill_ppn = ppn; refill_ro = ro;
    tick();
  endtask

  task automatic load_cfg(input logic [31:0] b, input logic [31:0] bd, input logic [31:0] s);
    cfg_load = 1'b1; cfg_data_base = b; cfg_data_bound = bd; cfg_stack_base = s;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    model_clear();
    repeat (3) @(negedge clk);
    // R12: reset state
    chk("R12", "resp_valid", resp_valid, 0);
    chk("R12", "stall", stall, 0);
    rst_n = 1'b1;
    @(negedge clk);
    acc(1, 32'h0000_5000, 0, 0);                 // R12 empty after reset
    load_cfg(32'h0001_0000, 32'h0002_0000, 32'hC000_0000); tick();
    acc(1, 32'hBFFF_F123, 0, 0);                 // R4 stack miss
    fill(2'd0, 20'hBFFFF, 20'h12345, 0);
    acc(1, 32'hBFFF_F008, 0, 0);                 // R5 hit
    fill(2'd0, 20'hBFFFE, 20'h00ABC, 1);
    acc(1, 32'hBFFF_F000, 1, 32'hBFFF_E010);     // R7 dual stack
    for (int i = 0; i < 8; i++) fill(2'd1, 20'h00010 + 20'(i), 20'h00100 + 20'(i), i[0]);
    acc(1, 32'h0001_0000, 1, 32'h0001_1000);     // R8 global clash
    acc(1, 32'h0001_2000, 1, 32'h0001_1000);     // R9 port 1 priority
    acc(1, 32'h0001_2000, 0, 0);
    fill(2'd1, 20'h00018, 20'h00200, 0);         // R6 evicts entry 0
    acc(1, 32'h0001_0000, 1, 32'hBFFF_F000);
    acc(1, 32'h0001_1000, 0, 0);
    fill(2'd1, 20'h00019, 20'h00201, 1);         // R6 evicts entry 1
    acc(1, 32'h0001_1000, 0, 0);
    acc(1, 32'h0001_9000, 0, 0);
    fill(2'd2, 20'h00030, 20'h00300, 1);
    acc(1, 32'h0003_0000, 1, 32'h0004_0000);     // R8 heap clash
    acc(0, 0, 1, 32'h0004_0000);
    fill(2'd2, 20'h0001F, 20'h00777, 0);         // R2 foreign region entry
    acc(1, 32'h0001_F000, 0, 0);
    acc(1, 32'h0002_0000, 1, 32'h0001_0FFF);     // R1 bound edges
    acc(1, 32'hBFF0_0000, 1, 32'hBFEF_FFFF);     // R1 stack floor edge
    acc(1, 32'h0000_FFFF, 1, 32'hFFFF_F000);
    flush = 1'b1; acc(1, 32'hBFFF_F000, 0, 0);   // R10 same-cycle old view
    acc(1, 32'hBFFF_F000, 1, 32'h0003_0000);     // R10 cleared
    flush = 1'b1; fill(2'd0, 20'hBFFF0, 20'h0AAAA, 0);  // R10 flush beats refill
    acc(1, 32'hBFFF_0000, 0, 0);
    fill(2'd0, 20'hBFFFF, 20'h0BBBB, 0);
    load_cfg(32'h0003_0000, 32'h0004_0000, 32'hC000_0000);
    acc(1, 32'h0003_0000, 1, 32'hBFFF_F000);     // R11 old bounds this cycle
    acc(1, 32'h0003_0000, 1, 32'hBFFF_F000);     // R11 new bounds, flushed
    for (int i = 0; i < 5; i++) fill(2'd0, 20'hBFFF0 + 20'(i), 20'h00400 + 20'(i), 0);
    acc(1, 32'hBFFF_0000, 1, 32'hBFFF_1000);     // R6 stack wrap
    acc(1, 32'hBFFF_4000, 0, 0);
    finish_run();
  end
endmodule